// File: doc/BRIEF.md
# Host Data Port with Half-Word Availability Count

This block is the host-facing message and data interface of an instrument. A host reaches it over a simple 32-bit register bus (select, write strobe, address, byte enables, write data, combinational read data). Behind the bus sit five resources. Two 32-bit scratch words are shared with an on-board processor. An outgoing FIFO carries measurement words from the processor to the host, and an incoming FIFO carries source words from the host to the processor. A count register reports availability in 16-bit units. A 32-bit command/response word is shared with the processor and raises a processor interrupt when its final byte is written.

The processor side has its own strobes and data paths. It writes scratch words, pushes measurement words, pops source words, reads the command word, and sets the two ready flags: command-ready and query-ready. When the host writes the least significant byte of the command word, both flags clear and the processor receives a one-cycle interrupt pulse. That byte is the one at the highest byte address, carried on byte lane 0.

Top module: `host_data_port`

## Requirements
- R1: Addresses 0 and 1 are scratch words that the host reads and writes as full 32-bit words. The processor writes them through `proc_ram_we`/`proc_ram_idx` and reads them on `proc_ram_rdata`. When the host and the processor write the same word in the same cycle, the host value is stored.
- R2: A host read at address 2 returns the oldest word in the outgoing FIFO in the same cycle and removes it at the clock edge. Words leave in the order the processor pushed them with `proc_tx_push`.
- R3: A host read at address 2 while the outgoing FIFO is empty returns 0 and leaves the FIFO empty. A later count read still reports 0.
- R4: A host write at address 3 appends the word to the incoming FIFO. The processor sees the oldest word on `proc_rx_data` (0 when empty, with `proc_rx_empty` high) and removes it with `proc_rx_pop`.
- R5: A host write at address 3 while the incoming FIFO is full is dropped and sets `rx_overflow` on the next cycle. The flag stays set until reset.
- R6: A host read at address 4 returns, in bits 15:0, the send count when `count_sel`=0 or the receive count when `count_sel`=1. The send count is twice the number of outgoing words. The receive count is twice the number of free incoming entries. The value saturates at 0xFFFF, bits 31:16 read 0, and it reflects the FIFO state at the start of the cycle, so it never exceeds the true amount.
- R7: Address 5 is the command word. A host write updates byte k (bits 8k+7:8k) only where `bus_be[k]`=1. The host reads the word back at address 5, and the processor sees it on `proc_cmd_word`.
- R8: A host write to address 5 with `bus_be[0]`=1 drives `cmd_ready` and `query_ready` to 0 and `proc_irq` to 1, all on the next cycle. `proc_irq` then stays high for exactly that one cycle. A command write with `bus_be[0]`=0 changes none of the three.
- R9: `proc_set_cmd_rdy` and `proc_set_qry_rdy` set `cmd_ready` and `query_ready` on the next cycle. If the host's lane-0 command write lands in the same cycle, the clear wins.
- R10: After reset both FIFOs are empty, the scratch and command words read 0, all flags and `proc_irq` are 0, the send count reads 0 and the receive count reads twice the FIFO depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables (command word only) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational |
| count_sel | input | 1 | 0 = send count, 1 = receive count |
| proc_ram_we | input | 1 | Processor scratch write |
| proc_ram_idx | input | 1 | Processor scratch word select |
| proc_ram_wdata | input | 32 | Processor scratch write data |
| proc_ram_rdata | output | 32 | Processor scratch read data |
| proc_tx_push | input | 1 | Push into outgoing FIFO |
| proc_tx_data | input | 32 | Outgoing word |
| proc_tx_full | output | 1 | Outgoing FIFO full |
| proc_rx_pop | input | 1 | Pop from incoming FIFO |
| proc_rx_data | output | 32 | Oldest incoming word |
| proc_rx_empty | output | 1 | Incoming FIFO empty |
| proc_cmd_word | output | 32 | Command word as seen by the processor |
| proc_set_cmd_rdy | input | 1 | Set command-ready flag |
| proc_set_qry_rdy | input | 1 | Set query-ready flag |
| cmd_ready | output | 1 | Command/parameter ready flag |
| query_ready | output | 1 | Query response ready flag |
| proc_irq | output | 1 | One-cycle interrupt to the processor |
| rx_overflow | output | 1 | Sticky incoming-FIFO overflow flag |

## Verification
The bench builds the block with a FIFO depth of 4. At that depth, a handful of random operations drive both FIFOs to full and to empty, so dropped writes, empty reads and every count value from 0 to 8 occur many times. The 16-bit saturation branch of the count cannot be reached at this depth, because it needs more than 32767 entries. Directed cycles cover the same-cycle collisions: the host clear against a processor set of the flags, and host against processor writes to a scratch word.

// File: rtl/hdp_pkg.sv
`timescale 1ns/1ps
// Shared constants of the host data port: bus word map and widths.
// Assumes a 3-bit word address on the host bus.
package hdp_pkg;
    localparam int DATA_W  = 32;
    localparam int COUNT_W = 16;
    localparam int NUM_RAM = 2;
    localparam logic [2:0] ADR_RAM0  = 3'd0;
    localparam logic [2:0] ADR_RAM1  = 3'd1;
    localparam logic [2:0] ADR_SEND  = 3'd2;
    localparam logic [2:0] ADR_RECV  = 3'd3;
    localparam logic [2:0] ADR_COUNT = 3'd4;
    localparam logic [2:0] ADR_CMD   = 3'd5;
endpackage

// File: rtl/hdp_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with occupancy output.
// A push while full and a pop while empty are ignored. The head reads 0 when empty.
// Assumes DEPTH >= 2.
module hdp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (occ == OCC_W'(DEPTH));
    assign empty   = (occ == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            occ <= occ + OCC_W'(push_ok) - OCC_W'(pop_ok);
        end
    end

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (occ == '0));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));
endmodule

// File: rtl/hdp_count.sv
`timescale 1ns/1ps
// Availability count in 16-bit units: twice the outgoing occupancy or twice the
// free incoming entries, saturated to the count width. Purely combinational.
module hdp_count #(
    parameter int DEPTH = 4,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic [OCC_W-1:0]           tx_occ,
    input  logic [OCC_W-1:0]           rx_occ,
    input  logic                       sel_rx,
    output logic [hdp_pkg::COUNT_W-1:0] value
);
    logic [31:0] units;

    // Scale the selected entry count to half-words and saturate.
    always_comb begin
        units = sel_rx ? ((32'(DEPTH) - 32'(rx_occ)) << 1) : (32'(tx_occ) << 1);
        value = (units > 32'(2**hdp_pkg::COUNT_W - 1)) ? '1 : units[hdp_pkg::COUNT_W-1:0];
    end
endmodule

// File: rtl/host_data_port.sv
`timescale 1ns/1ps
// Host data port: shared scratch words, outgoing and incoming FIFOs, a
// half-word availability count and a command word that interrupts the
// processor when its lane-0 byte is written. Host reads are combinational.
// Host writes take priority over processor writes to shared storage.
module host_data_port #(
    parameter int FIFO_DEPTH = 4,
    localparam int DW    = hdp_pkg::DATA_W,
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [2:0]    bus_addr,
    input  logic [3:0]    bus_be,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          count_sel,
    input  logic          proc_ram_we,
    input  logic          proc_ram_idx,
    input  logic [DW-1:0] proc_ram_wdata,
    output logic [DW-1:0] proc_ram_rdata,
    input  logic          proc_tx_push,
    input  logic [DW-1:0] proc_tx_data,
    output logic          proc_tx_full,
    input  logic          proc_rx_pop,
    output logic [DW-1:0] proc_rx_data,
    output logic          proc_rx_empty,
    output logic [DW-1:0] proc_cmd_word,
    input  logic          proc_set_cmd_rdy,
    input  logic          proc_set_qry_rdy,
    output logic          cmd_ready,
    output logic          query_ready,
    output logic          proc_irq,
    output logic          rx_overflow
);
    import hdp_pkg::*;

    logic                      host_rd, host_wr;
    logic                      send_pop, recv_push, cmd_wr, cmd_lsb_wr;
    logic [DW-1:0]             ram [NUM_RAM];
    logic [DW-1:0]             tx_head;
    logic [OCC_W-1:0]          tx_occ, rx_occ;
    logic                      tx_empty, rx_full;
    logic [COUNT_W-1:0]        count_val;

    assign host_rd    = bus_sel && !bus_we;
    assign host_wr    = bus_sel && bus_we;
    assign send_pop   = host_rd && (bus_addr == ADR_SEND);
    assign recv_push  = host_wr && (bus_addr == ADR_RECV);
    assign cmd_wr     = host_wr && (bus_addr == ADR_CMD);
    assign cmd_lsb_wr = cmd_wr && bus_be[0];

    // Shared scratch words, host wins a same-cycle collision.
    for (genvar i = 0; i < NUM_RAM; i++) begin : g_ram
        always_ff @(posedge clk) begin
            if (!rst_n)
                ram[i] <= '0;
            else if (host_wr && (bus_addr == 3'(i)))
                ram[i] <= bus_wdata;
            else if (proc_ram_we && (proc_ram_idx == 1'(i)))
                ram[i] <= proc_ram_wdata;
        end
    end
    assign proc_ram_rdata = ram[proc_ram_idx];

    // Command word, one register per byte lane.
    for (genvar k = 0; k < DW / 8; k++) begin : g_cmd
        always_ff @(posedge clk) begin
            if (!rst_n)
                proc_cmd_word[8*k +: 8] <= '0;
            else if (cmd_wr && bus_be[k])
                proc_cmd_word[8*k +: 8] <= bus_wdata[8*k +: 8];
        end
    end

    // Ready flags, interrupt pulse and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ready   <= 1'b0;
            query_ready <= 1'b0;
            proc_irq    <= 1'b0;
            rx_overflow <= 1'b0;
        end else begin
            proc_irq <= cmd_lsb_wr;
            if (cmd_lsb_wr) begin
                cmd_ready   <= 1'b0;
                query_ready <= 1'b0;
            end else begin
                if (proc_set_cmd_rdy) cmd_ready   <= 1'b1;
                if (proc_set_qry_rdy) query_ready <= 1'b1;
            end
            if (recv_push && rx_full) rx_overflow <= 1'b1;
        end
    end

    hdp_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(proc_tx_push), .wdata(proc_tx_data),
        .pop(send_pop), .head(tx_head),
        .occ(tx_occ), .full(proc_tx_full), .empty(tx_empty)
    );

    hdp_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(recv_push), .wdata(bus_wdata),
        .pop(proc_rx_pop), .head(proc_rx_data),
        .occ(rx_occ), .full(rx_full), .empty(proc_rx_empty)
    );

    hdp_count #(.DEPTH(FIFO_DEPTH)) u_count (
        .tx_occ(tx_occ), .rx_occ(rx_occ), .sel_rx(count_sel), .value(count_val)
    );

    // Host read data selection.
    always_comb begin
        bus_rdata = '0;
        if (host_rd) begin
            case (bus_addr)
                ADR_RAM0:  bus_rdata = ram[0];
                ADR_RAM1:  bus_rdata = ram[1];
                ADR_SEND:  bus_rdata = tx_head;
                ADR_COUNT: bus_rdata = {{(DW-COUNT_W){1'b0}}, count_val};
                ADR_CMD:   bus_rdata = proc_cmd_word;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R8
    irq_on_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lsb_wr |=> (proc_irq && !cmd_ready && !query_ready));
    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proc_irq) |-> $past(bus_sel && bus_we && bus_addr == ADR_CMD && bus_be[0]));
    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> rx_overflow);
    // R5
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overflow) |-> $past(recv_push && rx_full));
    // R9
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_set_cmd_rdy && !cmd_lsb_wr) |=> cmd_ready);
    // R3
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_pop && tx_empty) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_host_data_port.sv
`timescale 1ns/1ps
// Self-checking bench: reference queues and registers in the bench, random
// operations from a fixed seed plus directed collision and boundary cases.
module tb_host_data_port;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we, count_sel;
    logic [2:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic        proc_ram_we, proc_ram_idx;
    logic [31:0] proc_ram_wdata, proc_ram_rdata;
    logic        proc_tx_push, proc_tx_full, proc_rx_pop, proc_rx_empty;
    logic [31:0] proc_tx_data, proc_rx_data, proc_cmd_word;
    logic        proc_set_cmd_rdy, proc_set_qry_rdy;
    logic        cmd_ready, query_ready, proc_irq, rx_overflow;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit [31:0] txq[$];
    bit [31:0] rxq[$];
    bit [31:0] m_ram [2];
    bit [31:0] m_cmd;
    bit        m_crdy, m_qrdy, m_irq, m_ovf;

    always #5 clk = ~clk;

    host_data_port #(.FIFO_DEPTH(DEPTH)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_count(input bit sel);
        int u;
        u = sel ? (DEPTH - rxq.size()) * 2 : txq.size() * 2;
        return (u > 65535) ? 32'h0000FFFF : 32'(u);
    endfunction

    task automatic idle();
        bus_sel = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
        count_sel = 0; proc_ram_we = 0; proc_ram_idx = 0; proc_ram_wdata = 0;
        proc_tx_push = 0; proc_tx_data = 0; proc_rx_pop = 0;
        proc_set_cmd_rdy = 0; proc_set_qry_rdy = 0;
    endtask

    // Registered outputs checked at the falling edge after each cycle.
    task automatic check_regs();
        chk("R8 irq", 32'(proc_irq), 32'(m_irq));
        chk("R9 cmd_ready", 32'(cmd_ready), 32'(m_crdy));
        chk("R9 query_ready", 32'(query_ready), 32'(m_qrdy));
        chk("R5 overflow", 32'(rx_overflow), 32'(m_ovf));
        chk("R4 rx_data", proc_rx_data, rxq.size() ? rxq[0] : 32'h0);
        chk("R4 rx_empty", 32'(proc_rx_empty), 32'(rxq.size() == 0));
        chk("R2 tx_full", 32'(proc_tx_full), 32'(txq.size() == DEPTH));
        chk("R7 cmd_word", proc_cmd_word, m_cmd);
    endtask

    // Finish a cycle whose inputs are already driven; model updates via flags.
    task automatic finish_cycle(input bit lsb, input bit set_c, input bit set_q);
        @(posedge clk);
        m_irq = lsb;
        if (lsb) begin m_crdy = 0; m_qrdy = 0; end
        else begin
            if (set_c) m_crdy = 1;
            if (set_q) m_qrdy = 1;
        end
        @(negedge clk);
        idle();
        check_regs();
    endtask

    task automatic host_read(input bit [2:0] a, input bit sel, input bit [31:0] exp, input string req);
        bus_sel = 1; bus_we = 0; bus_addr = a; count_sel = sel;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic do_op(input int op);
        bit [31:0] d;
        bit [3:0]  be;
        bit        r;
        d = $urandom;
        r = 1'($urandom_range(0, 1));
        case (op)
            0: begin
                proc_ram_idx = r;
                host_read(3'(r), 0, m_ram[r], "R1 ram read");
                chk("R1 proc ram read", proc_ram_rdata, m_ram[r]);
                finish_cycle(0, 0, 0);
            end
            1: begin
                bus_sel = 1; bus_we = 1; bus_addr = 3'(r); bus_wdata = d;
                m_ram[r] = d;
                finish_cycle(0, 0, 0);
            end
            2: begin
                host_read(3'd2, 0, txq.size() ? txq[0] : 32'h0, txq.size() ? "R2 send read" : "R3 empty send read");
                if (txq.size()) void'(txq.pop_front());
                finish_cycle(0, 0, 0);
            end
            3: begin
                bus_sel = 1; bus_we = 1; bus_addr = 3'd3; bus_wdata = d;
                if (rxq.size() < DEPTH) rxq.push_back(d); else m_ovf = 1;
                finish_cycle(0, 0, 0);
            end
            4: begin
                host_read(3'd4, r, exp_count(r), "R6 count");
                finish_cycle(0, 0, 0);
            end
            5: begin
                be = 4'($urandom_range(0, 15));
                bus_sel = 1; bus_we = 1; bus_addr = 3'd5; bus_be = be; bus_wdata = d;
                for (int k = 0; k < 4; k++) if (be[k]) m_cmd[8*k +: 8] = d[8*k +: 8];
                finish_cycle(be[0], 0, 0);
            end
            6: begin
                host_read(3'd5, 0, m_cmd, "R7 cmd read");
                finish_cycle(0, 0, 0);
            end
            7: begin
                proc_tx_push = 1; proc_tx_data = d;
                if (txq.size() < DEPTH) txq.push_back(d);
                finish_cycle(0, 0, 0);
            end
            8: begin
                proc_rx_pop = 1;
                if (rxq.size()) void'(rxq.pop_front());
                finish_cycle(0, 0, 0);
            end
            9: begin
                be = 4'($urandom_range(0, 3));
                proc_set_cmd_rdy = be[0]; proc_set_qry_rdy = be[1];
                finish_cycle(0, be[0], be[1]);
            end
            default: begin
                proc_ram_we = 1; proc_ram_idx = r; proc_ram_wdata = d;
                m_ram[r] = d;
                finish_cycle(0, 0, 0);
            end
        endcase
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        idle();
        rst_n = 0;
        m_ram[0] = 0; m_ram[1] = 0; m_cmd = 0;
        m_crdy = 0; m_qrdy = 0; m_irq = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check_regs();
        host_read(3'd4, 0, 32'h0, "R10 send count");
        finish_cycle(0, 0, 0);
        host_read(3'd4, 1, 32'(2 * DEPTH), "R10 recv count");
        finish_cycle(0, 0, 0);
        host_read(3'd0, 0, 32'h0, "R10 ram0");
        finish_cycle(0, 0, 0);
        host_read(3'd5, 0, 32'h0, "R10 cmd");
        finish_cycle(0, 0, 0);

        // R3 empty send read leaves count at zero
        do_op(2);
        host_read(3'd4, 0, 32'h0, "R3 count after empty read");
        finish_cycle(0, 0, 0);

        // R5 fill incoming FIFO then overflow
        for (int i = 0; i <= DEPTH; i++) do_op(3);
        host_read(3'd4, 1, 32'h0, "R6 recv count full");
        finish_cycle(0, 0, 0);
        for (int i = 0; i < DEPTH; i++) do_op(8);
        chk("R5 overflow sticky", 32'(rx_overflow), 32'h1);

        // R2/R6 fill outgoing FIFO
        for (int i = 0; i <= DEPTH; i++) do_op(7);
        host_read(3'd4, 0, 32'(2 * DEPTH), "R6 send count full");
        finish_cycle(0, 0, 0);
        for (int i = 0; i < DEPTH; i++) do_op(2);

        // R9 set flags, then host lane-0 clear collides with a set
        proc_set_cmd_rdy = 1; proc_set_qry_rdy = 1;
        finish_cycle(0, 1, 1);
        bus_sel = 1; bus_we = 1; bus_addr = 3'd5; bus_be = 4'b0001; bus_wdata = 32'h000000A5;
        proc_set_cmd_rdy = 1; proc_set_qry_rdy = 1;
        m_cmd[7:0] = 8'hA5;
        finish_cycle(1, 1, 1);
        chk("R9 clear wins", 32'(cmd_ready), 32'h0);
        finish_cycle(0, 0, 0);
        chk("R8 irq one cycle", 32'(proc_irq), 32'h0);

        // R8 upper lanes only: flags untouched, no interrupt
        proc_set_cmd_rdy = 1;
        finish_cycle(0, 1, 0);
        bus_sel = 1; bus_we = 1; bus_addr = 3'd5; bus_be = 4'b1110; bus_wdata = 32'h12345678;
        m_cmd[31:8] = 24'h123456;
        finish_cycle(0, 0, 0);
        chk("R8 no irq without lane 0", 32'(proc_irq), 32'h0);
        chk("R8 ready kept", 32'(cmd_ready), 32'h1);

        // R1 host and processor write same word in one cycle
        bus_sel = 1; bus_we = 1; bus_addr = 3'd1; bus_wdata = 32'hCAFE0001;
        proc_ram_we = 1; proc_ram_idx = 1; proc_ram_wdata = 32'hBEEF0002;
        m_ram[1] = 32'hCAFE0001;
        finish_cycle(0, 0, 0);
        host_read(3'd1, 0, 32'hCAFE0001, "R1 host wins");
        finish_cycle(0, 0, 0);

        // Random mix
        for (int i = 0; i < 1500; i++) do_op($urandom_range(0, 10));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule